// File: doc/BRIEF.md
# Serial Receive Character Queue with Data-Available Threshold

This block stores characters handed over by a serial deserializer until the host reads them. Each stored entry carries the eight data bits and three error flags: parity error, framing error and break. The flags travel with their character, so the host always sees the errors that belong to the character at the head of the queue. The block runs in one of two modes. In the first, it holds one character only, like a plain holding register. In the second, it is a 16-entry first-in first-out queue.

The host configures the block by writing one control byte. The bits of that byte do the following:
- Bit 0 selects the mode.
- Bit 1 empties the receive queue.
- Bit 2 sends a one-cycle empty request to the transmit side.
- Bit 3 is a stored transfer-mode bit that has no effect inside the block.
- Bits 7:6 choose how many stored characters raise the data-available request.

A mode controller holds the mode and has two states. In `ST_HOLD` the FIFO is disabled and the capacity is one character. In `ST_FIFO` the capacity is 16 characters. A control write with bit 0 = 1 takes `ST_HOLD` to `ST_FIFO`. A control write with bit 0 = 0 takes `ST_FIFO` to `ST_HOLD`. A write that leaves bit 0 unchanged keeps the current state. Every state change also empties the receive store.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset the block is in `ST_HOLD`. The store is empty, `data_ready`, `overrun`, `level_hit` and `tx_flush` are 0, and `trig_sel` and `dma_sel` are 0.
- R2: A control write with bit 0 = 1 selects `ST_FIFO`, which holds 16 characters. Bit 0 = 0 selects `ST_HOLD`, which holds 1 character. A write that changes the mode also empties the store on the clock edge after the write.
- R3: Characters leave in arrival order. `head_*` shows the oldest stored character. A `host_rd_data` strobe removes that character. A strobe while the store is empty has no effect.
- R4: `data_ready` is 1 exactly when at least one character is stored.
- R5: A character that arrives when the store is at capacity, with no read in the same cycle, is discarded, and `overrun` sets. A character that arrives at capacity together with a read is accepted.
- R6: `overrun` stays at 1 until a `host_rd_stat` strobe clears it. If a new overrun happens in the same cycle as the strobe, the new overrun wins and `overrun` stays 1.
- R7: Control bit 1 = 1 empties the store on the clock edge after the write. Any arrival or read in that following cycle is ignored. The bit is not stored.
- R8: Control bit 2 = 1 raises `tx_flush` for exactly the one cycle after the write. The bit is not stored.
- R9: Control bits 7:6 pick the threshold: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14. In `ST_FIFO`, `level_hit` is 1 while the stored count is at least the threshold. In `ST_HOLD` the threshold is always 1.
- R10: Control bit 3 is stored and shown on `dma_sel`. It has no effect on storage or on the other status outputs.
- R11: The parity, framing and break flags received with a character come out on `head_perr`, `head_ferr` and `head_brk` whenever that character is at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_byte | input | 8 | Control byte value |
| rx_valid | input | 1 | A received character is offered this cycle |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error flag of the received character |
| rx_ferr | input | 1 | Framing error flag of the received character |
| rx_brk | input | 1 | Break flag of the received character |
| host_rd_data | input | 1 | Host read of the head character |
| host_rd_stat | input | 1 | Host read of status; clears overrun |
| head_data | output | 8 | Character at the head of the store |
| head_perr | output | 1 | Parity error flag of the head character |
| head_ferr | output | 1 | Framing error flag of the head character |
| head_brk | output | 1 | Break flag of the head character |
| data_ready | output | 1 | At least one character is stored |
| overrun | output | 1 | Sticky flag: a character was lost |
| level_hit | output | 1 | Stored count is at or above the threshold |
| fifo_on | output | 1 | 1 in `ST_FIFO`, 0 in `ST_HOLD` |
| trig_sel | output | 2 | Stored threshold code |
| dma_sel | output | 1 | Stored transfer-mode bit |
| tx_flush | output | 1 | One-cycle transmit empty request |

## Verification
The bench drives the store to its limit in both modes. At the limit it sends one more character, once alone and once together with a read. A design that wraps its write pointer would overwrite the oldest entry and corrupt the head. A design that ignores the simultaneous read would drop a character it could have accepted.

The bench also targets the cycle right after a clear or a mode change, where it sends arrivals and reads that must be lost. A design that clears in the same cycle as the write, or that lets a push through in the clear cycle, would leave a stale count.

Each threshold code is tested by reading the count down across its boundary. A wrong code mapping, or a `>` used in place of `>=`, shifts the edge of `level_hit` by one character.

Overrun is tested with a new overrun and a status read in the same cycle. A design that lets the clear win would lose the flag.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rxq_entry_t;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_FIFO = 1'b1
    } rxq_mode_e;

    function automatic int unsigned trig_level(input logic [1:0] code);
        int unsigned lvl;
        unique case (code)
            2'b00:   lvl = 1;
            2'b01:   lvl = 4;
            2'b10:   lvl = 8;
            default: lvl = 14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_ctl.sv
module rxq_ctl
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_byte,
    output rxq_mode_e  mode,
    output logic [1:0] trig_code,
    output logic       dma_bit,
    output logic       flush_rx,
    output logic       tx_flush
);

    rxq_mode_e mode_nxt;
    logic      mode_change;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= ST_HOLD;
        else        mode <= mode_nxt;
    end

    // transitions
    always_comb begin
        mode_nxt = mode;
        if (ctl_wr) begin
            unique case (mode)
                ST_HOLD: if (ctl_byte[0])  mode_nxt = ST_FIFO;
                ST_FIFO: if (!ctl_byte[0]) mode_nxt = ST_HOLD;
                default: mode_nxt = ST_HOLD;
            endcase
        end
    end

    assign mode_change = (mode_nxt != mode);

    // registered outputs: stored fields and one-shot commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_code <= 2'b00;
            dma_bit   <= 1'b0;
            flush_rx  <= 1'b0;
            tx_flush  <= 1'b0;
        end else begin
            flush_rx <= ctl_wr && (ctl_byte[1] || mode_change);
            tx_flush <= ctl_wr && ctl_byte[2];
            if (ctl_wr) begin
                trig_code <= ctl_byte[7:6];
                dma_bit   <= ctl_byte[3];
            end
        end
    end

    AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_byte[2] |=> tx_flush); // R8
    AST_TX_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> !tx_flush); // R8
    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && (ctl_byte[0] != (mode == ST_FIFO)) |=> flush_rx); // R2

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          push_vld,
    input  rxq_entry_t    push_ent,
    input  logic          pop_req,
    input  logic          flush,
    input  logic          ovr_clr,
    output rxq_entry_t    head,
    output logic [CW-1:0] count,
    output logic          overrun
);

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          full, do_pop, do_push, ovr_evt;

    assign cap     = fifo_en ? CW'(DEPTH) : CW'(1);
    assign full    = (count >= cap);
    assign do_pop  = pop_req && (count != '0) && !flush;
    assign do_push = push_vld && !flush && (!full || do_pop);
    assign ovr_evt = push_vld && !flush && full && !do_pop;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       overrun <= 1'b0;
        else if (ovr_evt) overrun <= 1'b1;
        else if (ovr_clr) overrun <= 1'b0;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !ovr_clr |=> overrun); // R6
    AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld && full && !pop_req && !flush |=> $stable(count) && overrun); // R5

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_byte,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_brk,
    input  logic       host_rd_data,
    input  logic       host_rd_stat,
    output logic [7:0] head_data,
    output logic       head_perr,
    output logic       head_ferr,
    output logic       head_brk,
    output logic       data_ready,
    output logic       overrun,
    output logic       level_hit,
    output logic       fifo_on,
    output logic [1:0] trig_sel,
    output logic       dma_sel,
    output logic       tx_flush
);

    localparam int CW = $clog2(DEPTH + 1);

    rxq_mode_e     mode;
    logic          flush_rx;
    rxq_entry_t    in_ent, head_ent;
    logic [CW-1:0] count, thr;

    rxq_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_byte  (ctl_byte),
        .mode      (mode),
        .trig_code (trig_sel),
        .dma_bit   (dma_sel),
        .flush_rx  (flush_rx),
        .tx_flush  (tx_flush)
    );

    assign fifo_on = (mode == ST_FIFO);
    assign in_ent  = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_on),
        .push_vld (rx_valid),
        .push_ent (in_ent),
        .pop_req  (host_rd_data),
        .flush    (flush_rx),
        .ovr_clr  (host_rd_stat),
        .head     (head_ent),
        .count    (count),
        .overrun  (overrun)
    );

    assign thr        = fifo_on ? CW'(trig_level(trig_sel)) : CW'(1);
    assign level_hit  = (count >= thr);
    assign data_ready = (count != '0);
    assign head_data  = head_ent.data;
    assign head_perr  = head_ent.perr;
    assign head_ferr  = head_ent.ferr;
    assign head_brk   = head_ent.brk;

    AST_LEVEL_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        level_hit |-> data_ready); // R9
    AST_READY_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !flush_rx && !host_rd_data |=> data_ready); // R4

endmodule

// File: tb/test_rx_char_fifo.sv
module test_rx_char_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_byte = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic       host_rd_data = 1'b0, host_rd_stat = 1'b0;
    logic [7:0] head_data;
    logic       head_perr, head_ferr, head_brk;
    logic       data_ready, overrun, level_hit, fifo_on, dma_sel, tx_flush;
    logic [1:0] trig_sel;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    rx_char_fifo i_rx_char_fifo (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .host_rd_data(host_rd_data),
        .host_rd_stat(host_rd_stat), .head_data(head_data),
        .head_perr(head_perr), .head_ferr(head_ferr), .head_brk(head_brk),
        .data_ready(data_ready), .overrun(overrun), .level_hit(level_hit),
        .fifo_on(fifo_on), .trig_sel(trig_sel), .dma_sel(dma_sel),
        .tx_flush(tx_flush)
    );

    // reference model: entry = {brk, ferr, perr, data}
    logic [10:0] q[$];
    bit       m_en, m_dma, m_ovr, m_flp, m_txp;
    bit [1:0] m_trig;

    function automatic int thr_of(bit en, bit [1:0] code);
        if (!en) return 1;
        case (code)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_en = 0; m_dma = 0; m_ovr = 0; m_flp = 0; m_txp = 0; m_trig = 0;
        end else begin
            bit set_ovr;
            set_ovr = 0;
            if (m_flp) q.delete();
            else begin
                int  cap;
                bit  pop, full;
                cap  = m_en ? 16 : 1;
                pop  = host_rd_data && (q.size() > 0);
                full = (q.size() >= cap);
                if (rx_valid && full && !pop) set_ovr = 1;
                if (pop) void'(q.pop_front());
                if (rx_valid && (!full || pop))
                    q.push_back({rx_brk, rx_ferr, rx_perr, rx_data});
            end
            if (set_ovr) m_ovr = 1;
            else if (host_rd_stat) m_ovr = 0;
            m_flp = ctl_wr && (ctl_byte[1] || (ctl_byte[0] != m_en));
            m_txp = ctl_wr && ctl_byte[2];
            if (ctl_wr) begin
                m_en = ctl_byte[0]; m_trig = ctl_byte[7:6]; m_dma = ctl_byte[3];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(data_ready == (q.size() > 0), "R4", "data_ready", data_ready, q.size() > 0);
            chk(overrun == m_ovr, "R6", "overrun", overrun, m_ovr);
            chk(level_hit == (q.size() >= thr_of(m_en, m_trig)), "R9", "level_hit",
                level_hit, q.size() >= thr_of(m_en, m_trig));
            chk(fifo_on == m_en, "R2", "fifo_on", fifo_on, m_en);
            chk(trig_sel == m_trig, "R9", "trig_sel", trig_sel, m_trig);
            chk(dma_sel == m_dma, "R10", "dma_sel", dma_sel, m_dma);
            chk(tx_flush == m_txp, "R8", "tx_flush", tx_flush, m_txp);
            if (q.size() > 0) begin
                chk(head_data == q[0][7:0], "R3", "head_data", head_data, q[0][7:0]);
                chk({head_brk, head_ferr, head_perr} == q[0][10:8], "R11", "head_flags",
                    {head_brk, head_ferr, head_perr}, q[0][10:8]);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 0; rx_valid = 0; host_rd_data = 0; host_rd_stat = 0;
    endtask

    task automatic wr_ctl(input logic [7:0] b);
        ctl_wr = 1; ctl_byte = b; tick();
    endtask

    task automatic send(input logic [7:0] d, input logic [2:0] f);
        rx_valid = 1; rx_data = d; {rx_brk, rx_ferr, rx_perr} = f; tick();
    endtask

    task automatic rd(); host_rd_data = 1; tick(); endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);   // R1 reset state compared while held
        rst_n = 1; @(negedge clk);
        // R1 explicit
        chk(!data_ready && !overrun && !level_hit && !fifo_on && !tx_flush,
            "R1", "reset outputs", {data_ready, overrun, level_hit, fifo_on, tx_flush}, 0);
        // hold mode: one slot, second char overruns (R5, R2)
        send(8'hA1, 3'b001);
        send(8'hA2, 3'b000);
        chk(overrun && head_data == 8'hA1, "R5", "hold overrun", {overrun, head_data}, 9'h1A1);
        host_rd_stat = 1; tick();    // R6 clear
        rd(); rd();                  // second read on empty ignored (R3)
        // full + simultaneous read accepted in hold mode (R5)
        send(8'h11, 3'b010);
        rx_valid = 1; rx_data = 8'h12; host_rd_data = 1; tick();
        chk(head_data == 8'h12 && !overrun, "R5", "push with read", head_data, 8'h12);
        // switch to FIFO with threshold 4 and transfer bit; mode change empties (R2, R10)
        wr_ctl(8'b0100_1001);
        rx_valid = 1; rx_data = 8'h55; tick();  // ignored in clear cycle (R7)
        chk(!data_ready, "R7", "clear cycle push", data_ready, 0);
        for (int i = 0; i < 16; i++) send(8'(8'h20 + i), 3'(i));
        send(8'hEE, 3'b111);         // overrun at 16, discarded (R5)
        host_rd_stat = 1; rx_valid = 1; rx_data = 8'hEF; tick(); // set wins (R6)
        chk(overrun, "R6", "set beats clear", overrun, 1);
        for (int i = 0; i < 14; i++) rd();   // cross threshold 4 downward (R9)
        // thresholds 8 and 14 (R9)
        wr_ctl(8'b1000_0001);
        for (int i = 0; i < 10; i++) send(8'(i), 3'b100);
        wr_ctl(8'b1100_0001);
        for (int i = 0; i < 6; i++) send(8'(8'h40 + i), 3'b000);
        rd(); rd();
        // explicit clear and tx request (R7, R8)
        wr_ctl(8'b0000_0111);
        host_rd_data = 1; tick();
        chk(!data_ready, "R7", "clear", data_ready, 0);
        wr_ctl(8'b0000_0101);
        // back to hold mode (R2)
        send(8'h77, 3'b000);
        wr_ctl(8'b0000_0000);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            rx_valid = ($urandom % 3) == 0;
            rx_data = 8'($urandom);
            {rx_brk, rx_ferr, rx_perr} = 3'($urandom);
            host_rd_data = ($urandom % 4) == 0;
            host_rd_stat = ($urandom % 16) == 0;
            if (($urandom % 64) == 0) begin
                ctl_wr = 1;
                ctl_byte = 8'($urandom) | 8'h01;
                if (($urandom % 4) == 0) ctl_byte[0] = 1'b0;
                if (($urandom % 2) == 0) ctl_byte[1] = 1'b0;
            end
            tick();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule